// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block services a set of DMA channels, one element at a time. On every scan it looks at each enabled channel, checks whether the channel's flow type is satisfied by the peripheral request lines, and picks the lowest-numbered channel that is ready. For that channel it reads one element of the source width from memory and writes it back at the destination width. It then advances each address by its own width if that address is set to increment, and lowers the channel's 12-bit transfer count by one.

When a channel's count reaches zero, the transfer is complete. If the channel's linked-list pointer is nonzero, the engine fetches a four-word descriptor from memory and reloads the channel's source, destination, control and next-pointer registers from it. If the pointer is zero, the engine clears the channel's enable bit. A completed transfer whose control word asks for it sets a sticky terminal-count bit for that channel.

The channel registers are loaded through a simple write port and are visible as flat output vectors. Memory is reached through a single-word request/ready master port that carries byte enables.

Top module: `lldma_engine`

## Requirements
- R1: After reset every channel register (source, destination, next pointer, control, configuration) is zero, all terminal-count bits are zero and no memory request is raised.
- R2: A channel is serviced only while `glob_en` is high, configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0.
- R3: The flow type in configuration [13:11] gates service. The request vector is `per_sreq | per_breq`, indexed by the source peripheral number in configuration [5:1] and the destination peripheral number in [10:6]. Type 0 needs no request. Type 1 needs the destination request. Type 2 needs the source request. Type 3 needs both.
- R4: A channel whose flow type is 4 to 7 is never serviced, whatever the request lines are.
- R5: When several channels are eligible, the lowest-numbered one is serviced. The choice is made again before every element.
- R6: Each element is a word-aligned read at the source address followed by a word-aligned write at the destination address. Each access has byte enables equal to the width mask shifted left by the address's low two bits. Width codes are in control [20:18] (source) and [23:21] (destination): 0 is 1 byte, 1 is 2 bytes, 2 or more is 4 bytes. A request holds its address, direction and byte enables until `mem_ready`.
- R7: The element is taken from the source byte lanes, truncated or zero-extended to the destination width, and placed on the destination byte lanes.
- R8: Each service decrements control [11:0] and leaves control [31:12] unchanged.
- R9: After an element, the source address advances by the source width only if control bit 26 is set. The destination address advances by the destination width only if control bit 27 is set.
- R10: When the count reaches zero and the next pointer P is nonzero, the engine reads P+0 into source, P+4 into destination, P+12 into control and then P+8 into the next pointer, in that order. It then resumes scanning.
- R11: When the count reaches zero and the next pointer is zero, only configuration bit 0 is cleared. The engine itself never sets an enable bit.
- R12: A completed transfer sets that channel's bit in `tc_raw` if control bit 31 of the finished transfer was 1. A bit stays set until its `tc_clr` bit is pulsed.
- R13: A channel selected with a count of zero makes no data access and goes straight to completion handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_en | input | 1 | Global enable for servicing |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_ch | input | CH_W | Channel index for the write |
| cfg_reg | input | 3 | Register select: 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration |
| cfg_wdata | input | 32 | Write data |
| per_sreq | input | 32 | Single-request lines, one per peripheral |
| per_breq | input | 32 | Burst-request lines, one per peripheral |
| tc_clr | input | NUM_CH | Clears terminal-count bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| chan_src | output | NUM_CH*32 | Source addresses, channel i at [i*32+:32] |
| chan_dst | output | NUM_CH*32 | Destination addresses |
| chan_lli | output | NUM_CH*32 | Next-pointer registers |
| chan_ctrl | output | NUM_CH*32 | Control registers |
| chan_conf | output | NUM_CH*32 | Configuration registers |
| tc_raw | output | NUM_CH | Sticky terminal-count bits |

## Verification
The bench programs channels and runs them against a memory model that stalls on alternate cycles. It then checks the memory contents, the access log and the final register state. It probes each flow type with only the wrong request line, then with the right one, and mixes single and burst lines. A design that ANDs those lines, or swaps source and destination numbers, would stall or run early. Byte-to-word and halfword-to-byte moves at odd addresses expose lane shifts and byte enables that would corrupt neighbouring bytes. A descriptor-chained run checks the fetch order (+0, +4, +12, +8) and that the terminal-count bit comes from the finished control word rather than the reloaded one. A zero-count channel and two competing channels catch spurious accesses and priority that is decided once per transfer instead of once per element.

// File: rtl/lldma_pkg.sv
// Package: shared field positions, FSM encoding and width helpers for the
// linked-list DMA engine. Assumes 32-bit addresses and a 32-bit data bus.
package lldma_pkg;

    localparam int PERI_W = 5;
    localparam int NPER   = 1 << PERI_W;
    localparam int CNT_W  = 12;

    // configuration word bit positions
    localparam int CF_EN    = 0;
    localparam int CF_SRCP  = 1;
    localparam int CF_DSTP  = 6;
    localparam int CF_FLOW  = 11;
    localparam int CF_HALT  = 18;

    // control word bit positions
    localparam int CT_SW    = 18;
    localparam int CT_DW    = 21;
    localparam int CT_SINC  = 26;
    localparam int CT_DINC  = 27;
    localparam int CT_TCIE  = 31;

    // register select codes on the write port
    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_LLI  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_CONF = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_CNT,
        ST_DONE,
        ST_L0,
        ST_L1,
        ST_L2,
        ST_L3
    } eng_st_e;

    // element width in bytes; codes above 2 saturate at the bus width
    function automatic logic [31:0] width_bytes(input logic [2:0] code);
        case (code)
            3'd0:    width_bytes = 32'd1;
            3'd1:    width_bytes = 32'd2;
            default: width_bytes = 32'd4;
        endcase
    endfunction

    // data mask covering one element
    function automatic logic [31:0] width_mask(input logic [2:0] code);
        case (code)
            3'd0:    width_mask = 32'h0000_00FF;
            3'd1:    width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // byte enables for one element at the given low address bits
    function automatic logic [3:0] lane_be(input logic [2:0] code, input logic [1:0] lo);
        logic [3:0] base;
        case (code)
            3'd0:    base = 4'b0001;
            3'd1:    base = 4'b0011;
            default: base = 4'b1111;
        endcase
        lane_be = base << lo;
    endfunction

endpackage

// File: rtl/lldma_elig.sv
// Eligibility: per channel, decides whether it may be serviced now from
// its enable, halt and flow type, the global enable and the request lines.
// Assumes the request vector already merges single and burst lines.
module lldma_elig
    import lldma_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH*32-1:0] conf_flat,
    input  logic                 glob_en,
    input  logic [NPER-1:0]      per_req,
    output logic [NUM_CH-1:0]    elig
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [31:0]       conf;
        logic [PERI_W-1:0] sp;
        logic [PERI_W-1:0] dp;
        logic [2:0]        flow;
        logic              flow_ok;

        assign conf = conf_flat[g*32 +: 32];
        assign sp   = conf[CF_SRCP +: PERI_W];
        assign dp   = conf[CF_DSTP +: PERI_W];
        assign flow = conf[CF_FLOW +: 3];

        // flow type selects which request lines must be active
        always_comb begin
            case (flow)
                3'd0:    flow_ok = 1'b1;
                3'd1:    flow_ok = per_req[dp];
                3'd2:    flow_ok = per_req[sp];
                3'd3:    flow_ok = per_req[sp] & per_req[dp];
                default: flow_ok = 1'b0;
            endcase
        end

        assign elig[g] = glob_en & conf[CF_EN] & ~conf[CF_HALT] & flow_ok;
    end

endmodule

// File: rtl/lldma_prio.sv
// Fixed-priority picker: returns the lowest set index of the request
// vector. Assumes N >= 1.
module lldma_prio #(
    parameter int N    = 2,
    parameter int IDXW = 1
) (
    input  logic [N-1:0]    req,
    output logic [IDXW-1:0] idx,
    output logic            any
);

    // scan downward so the lowest set bit is the last to assign
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDXW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lldma_lane.sv
// Byte-lane steering: pulls one element off the source lanes of a read
// word, and places a held element on the destination lanes of a write
// word. Also produces the byte enables of both accesses. Assumes each
// address is aligned to its own element width.
module lldma_lane
    import lldma_pkg::*;
(
    input  logic [31:0] rdata,
    input  logic [1:0]  src_lo,
    input  logic [2:0]  src_code,
    input  logic [1:0]  dst_lo,
    input  logic [2:0]  dst_code,
    input  logic [31:0] elem_in,
    output logic [31:0] elem_out,
    output logic [31:0] wdata,
    output logic [3:0]  src_be,
    output logic [3:0]  dst_be
);

    logic [4:0] src_sh;
    logic [4:0] dst_sh;

    assign src_sh = {src_lo, 3'b000};
    assign dst_sh = {dst_lo, 3'b000};

    // shift the source lanes down to bit 0 and mask to the element width
    assign elem_out = (rdata >> src_sh) & width_mask(src_code);
    // trim to the destination width and shift onto its lanes
    assign wdata    = (elem_in & width_mask(dst_code)) << dst_sh;
    assign src_be   = lane_be(src_code, src_lo);
    assign dst_be   = lane_be(dst_code, dst_lo);

endmodule

// File: rtl/lldma_engine.sv
// Linked-list DMA channel engine top. Holds the channel register file,
// runs the service FSM (pick, read, write, update, complete, descriptor
// fetch) and drives a single-word request/ready memory master. Assumes
// the memory holds rdata valid in the cycle mem_ready is high, and that
// descriptor pointers are word aligned.
module lldma_engine
    import lldma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glob_en,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [2:0]           cfg_reg,
    input  logic [31:0]          cfg_wdata,
    input  logic [31:0]          per_sreq,
    input  logic [31:0]          per_breq,
    input  logic [NUM_CH-1:0]    tc_clr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [3:0]           mem_be,
    output logic [31:0]          mem_wdata,
    input  logic                 mem_ready,
    input  logic [31:0]          mem_rdata,
    output logic [NUM_CH*32-1:0] chan_src,
    output logic [NUM_CH*32-1:0] chan_dst,
    output logic [NUM_CH*32-1:0] chan_lli,
    output logic [NUM_CH*32-1:0] chan_ctrl,
    output logic [NUM_CH*32-1:0] chan_conf,
    output logic [NUM_CH-1:0]    tc_raw
);

    logic [31:0] src_r  [NUM_CH];
    logic [31:0] dst_r  [NUM_CH];
    logic [31:0] lli_r  [NUM_CH];
    logic [31:0] ctrl_r [NUM_CH];
    logic [31:0] conf_r [NUM_CH];

    eng_st_e         state;
    logic [CH_W-1:0] sel_q;
    logic [31:0]     elem_q;

    logic [NUM_CH-1:0] elig;
    logic [CH_W-1:0]   gidx;
    logic              gany;
    logic              ack;

    logic [31:0]      cur_src;
    logic [31:0]      cur_dst;
    logic [31:0]      cur_lli;
    logic [31:0]      cur_ctrl;
    logic [CNT_W-1:0] cnt_m1;
    logic [31:0]      elem_rd;
    logic [31:0]      lane_wdata;
    logic [3:0]       src_be;
    logic [3:0]       dst_be;

    // flatten the register file onto the output vectors
    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
        assign chan_src [g*32 +: 32] = src_r[g];
        assign chan_dst [g*32 +: 32] = dst_r[g];
        assign chan_lli [g*32 +: 32] = lli_r[g];
        assign chan_ctrl[g*32 +: 32] = ctrl_r[g];
        assign chan_conf[g*32 +: 32] = conf_r[g];
    end

    lldma_elig #(.NUM_CH(NUM_CH)) u_elig (
        .conf_flat (chan_conf),
        .glob_en   (glob_en),
        .per_req   (per_sreq | per_breq),
        .elig      (elig)
    );

    lldma_prio #(.N(NUM_CH), .IDXW(CH_W)) u_prio (
        .req (elig),
        .idx (gidx),
        .any (gany)
    );

    assign cur_src  = src_r[sel_q];
    assign cur_dst  = dst_r[sel_q];
    assign cur_lli  = lli_r[sel_q];
    assign cur_ctrl = ctrl_r[sel_q];
    assign cnt_m1   = cur_ctrl[CNT_W-1:0] - CNT_W'(1);

    lldma_lane u_lane (
        .rdata    (mem_rdata),
        .src_lo   (cur_src[1:0]),
        .src_code (cur_ctrl[CT_SW +: 3]),
        .dst_lo   (cur_dst[1:0]),
        .dst_code (cur_ctrl[CT_DW +: 3]),
        .elem_in  (elem_q),
        .elem_out (elem_rd),
        .wdata    (lane_wdata),
        .src_be   (src_be),
        .dst_be   (dst_be)
    );

    // memory master outputs decoded from the FSM state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        case (state)
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = {cur_src[31:2], 2'b00};
                mem_be   = src_be;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cur_dst[31:2], 2'b00};
                mem_be    = dst_be;
                mem_wdata = lane_wdata;
            end
            ST_L0: begin
                mem_req  = 1'b1;
                mem_addr = {cur_lli[31:2], 2'b00};
                mem_be   = 4'hF;
            end
            ST_L1: begin
                mem_req  = 1'b1;
                mem_addr = {cur_lli[31:2], 2'b00} + 32'd4;
                mem_be   = 4'hF;
            end
            ST_L2: begin
                mem_req  = 1'b1;
                mem_addr = {cur_lli[31:2], 2'b00} + 32'd12;
                mem_be   = 4'hF;
            end
            ST_L3: begin
                mem_req  = 1'b1;
                mem_addr = {cur_lli[31:2], 2'b00} + 32'd8;
                mem_be   = 4'hF;
            end
            default: ;
        endcase
    end

    assign ack = mem_req & mem_ready;

    // service sequencer: pick a channel, move one element, handle completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sel_q  <= '0;
            elem_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (gany) begin
                        sel_q <= gidx;
                        state <= (ctrl_r[gidx][CNT_W-1:0] == '0) ? ST_DONE : ST_RD;
                    end
                end
                ST_RD: begin
                    if (ack) begin
                        elem_q <= elem_rd;
                        state  <= ST_WR;
                    end
                end
                ST_WR:   if (ack) state <= ST_CNT;
                ST_CNT:  state <= (cnt_m1 == '0) ? ST_DONE : ST_IDLE;
                ST_DONE: state <= (cur_lli != '0) ? ST_L0 : ST_IDLE;
                ST_L0:   if (ack) state <= ST_L1;
                ST_L1:   if (ack) state <= ST_L2;
                ST_L2:   if (ack) state <= ST_L3;
                ST_L3:   if (ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // channel register file: port writes, then engine updates that override them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                src_r[i]  <= '0;
                dst_r[i]  <= '0;
                lli_r[i]  <= '0;
                ctrl_r[i] <= '0;
                conf_r[i] <= '0;
            end
        end else begin
            if (cfg_we) begin
                case (cfg_reg)
                    SEL_SRC:  src_r[cfg_ch]  <= cfg_wdata;
                    SEL_DST:  dst_r[cfg_ch]  <= cfg_wdata;
                    SEL_LLI:  lli_r[cfg_ch]  <= cfg_wdata;
                    SEL_CTRL: ctrl_r[cfg_ch] <= cfg_wdata;
                    SEL_CONF: conf_r[cfg_ch] <= cfg_wdata;
                    default: ;
                endcase
            end
            case (state)
                ST_CNT: begin
                    if (cur_ctrl[CT_SINC])
                        src_r[sel_q] <= cur_src + width_bytes(cur_ctrl[CT_SW +: 3]);
                    if (cur_ctrl[CT_DINC])
                        dst_r[sel_q] <= cur_dst + width_bytes(cur_ctrl[CT_DW +: 3]);
                    ctrl_r[sel_q] <= {cur_ctrl[31:CNT_W], cnt_m1};
                end
                ST_DONE: begin
                    if (cur_lli == '0)
                        conf_r[sel_q][CF_EN] <= 1'b0;
                end
                ST_L0: if (ack) src_r[sel_q]  <= mem_rdata;
                ST_L1: if (ack) dst_r[sel_q]  <= mem_rdata;
                ST_L2: if (ack) ctrl_r[sel_q] <= mem_rdata;
                ST_L3: if (ack) lli_r[sel_q]  <= mem_rdata;
                default: ;
            endcase
        end
    end

    // sticky terminal-count bits; a set in the same cycle beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_raw <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (state == ST_DONE && sel_q == CH_W'(i) && cur_ctrl[CT_TCIE])
                    tc_raw[i] <= 1'b1;
                else if (tc_clr[i])
                    tc_raw[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lldma_engine_chk.sv
// Checker for the DMA engine: memory handshake rules, byte-enable shape,
// enable-bit and terminal-count bit behaviour. Attached by bind below.
module lldma_engine_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [NUM_CH-1:0]    tc_clr,
    input logic [NUM_CH-1:0]    tc_raw,
    input logic [NUM_CH*32-1:0] chan_conf,
    input logic                 mem_req,
    input logic                 mem_ready,
    input logic                 mem_we,
    input logic [31:0]          mem_addr,
    input logic [3:0]           mem_be
);

    logic [NUM_CH-1:0] en_now;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_en
        assign en_now[g] = chan_conf[g*32];
    end

    // R6: a stalled request holds its address, direction and enables
    a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be)));

    // R6: byte enables cover exactly one element of 1, 2 or 4 bytes
    a_r6_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

    // R11: without a port write, no enable bit rises
    a_r11_engine_never_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ((en_now & ~$past(en_now)) == '0));

    // R12: a set terminal-count bit that is not cleared stays set
    a_r12_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_raw != '0) |=> ((tc_raw & $past(tc_raw & ~tc_clr)) == $past(tc_raw & ~tc_clr)));

    // R6: memory addresses are word aligned
    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

endmodule

bind lldma_engine lldma_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .tc_clr    (tc_clr),
    .tc_raw    (tc_raw),
    .chan_conf (chan_conf),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be)
);

// File: tb/lldma_engine_bench.sv
// Directed bench for the DMA engine with a stalling word memory model.
module lldma_engine_bench;

    localparam int NUM_CH = 2;
    localparam int CH_W   = 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 glob_en = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [CH_W-1:0]      cfg_ch = '0;
    logic [2:0]           cfg_reg = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [31:0]          per_sreq = '0;
    logic [31:0]          per_breq = '0;
    logic [NUM_CH-1:0]    tc_clr = '0;
    logic                 mem_req;
    logic                 mem_we;
    logic [31:0]          mem_addr;
    logic [3:0]           mem_be;
    logic [31:0]          mem_wdata;
    logic                 mem_ready = 1'b0;
    logic [31:0]          mem_rdata;
    logic [NUM_CH*32-1:0] chan_src;
    logic [NUM_CH*32-1:0] chan_dst;
    logic [NUM_CH*32-1:0] chan_lli;
    logic [NUM_CH*32-1:0] chan_ctrl;
    logic [NUM_CH*32-1:0] chan_conf;
    logic [NUM_CH-1:0]    tc_raw;

    lldma_engine #(.NUM_CH(NUM_CH)) u_lldma_engine (
        .clk, .rst_n, .glob_en, .cfg_we, .cfg_ch, .cfg_reg, .cfg_wdata,
        .per_sreq, .per_breq, .tc_clr,
        .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ready, .mem_rdata,
        .chan_src, .chan_dst, .chan_lli, .chan_ctrl, .chan_conf, .tc_raw
    );

    always #5 clk = ~clk;

    // memory model, access log and backdoor preload
    logic [31:0] mem [0:511];
    logic [31:0] log_addr [0:63];
    logic        log_we   [0:63];
    logic [3:0]  log_be   [0:63];
    logic [31:0] log_wd   [0:63];
    int          log_n = 0;
    logic        tb_wr_en = 1'b0;
    logic [31:0] tb_wr_addr = '0;
    logic [31:0] tb_wr_data = '0;
    logic        tb_log_clr = 1'b0;
    logic        stall_mode = 1'b1;

    assign mem_rdata = mem[mem_addr[10:2]];

    always @(posedge clk) begin
        if (tb_wr_en) mem[tb_wr_addr[10:2]] <= tb_wr_data;
        else if (mem_req && mem_ready && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[10:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        if (tb_log_clr) log_n <= 0;
        else if (mem_req && mem_ready && log_n < 64) begin
            log_addr[log_n] <= mem_addr;
            log_we[log_n]   <= mem_we;
            log_be[log_n]   <= mem_be;
            log_wd[log_n]   <= mem_wdata;
            log_n           <= log_n + 1;
        end
    end

    always @(negedge clk) mem_ready <= stall_mode ? ~mem_ready : 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    function automatic logic [31:0] fld(input logic [NUM_CH*32-1:0] v, input int ch);
        return v[ch*32 +: 32];
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_wr_en = 1'b1; tb_wr_addr = a; tb_wr_data = d;
        @(negedge clk);
        tb_wr_en = 1'b0;
    endtask

    task automatic clr_log();
        @(negedge clk); tb_log_clr = 1'b1;
        @(negedge clk); tb_log_clr = 1'b0;
    endtask

    task automatic wr_reg(input int ch, input logic [2:0] r, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_reg = r; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] l, input logic [31:0] c, input logic [31:0] f);
        wr_reg(ch, 3'd0, s);
        wr_reg(ch, 3'd1, d);
        wr_reg(ch, 3'd2, l);
        wr_reg(ch, 3'd3, c);
        wr_reg(ch, 3'd4, f);
    endtask

    task automatic wait_off(input int ch, input string req);
        int k = 0;
        while (chan_conf[ch*32] !== 1'b0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(k < 3000, req, 32'(k), 32'd3000);
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_tc();
        @(negedge clk); tc_clr = '1;
        @(negedge clk); tc_clr = '0;
    endtask

    task automatic t_reset();
        chk_eq("R1 src", chan_src[31:0] | chan_src[63:32], 32'h0);
        chk_eq("R1 ctrl", chan_ctrl[31:0] | chan_ctrl[63:32], 32'h0);
        chk_eq("R1 conf", chan_conf[31:0] | chan_conf[63:32] | chan_lli[31:0] | chan_dst[63:32], 32'h0);
        chk_eq("R1 tc", 32'(tc_raw), 32'h0);
        chk_eq("R1 req", 32'(mem_req), 32'h0);
    endtask

    task automatic t_mem2mem();
        poke(32'h100, 32'hA1A2A3A4); poke(32'h104, 32'hB1B2B3B4); poke(32'h108, 32'hC1C2C3C4);
        clr_log();
        prog(0, 32'h100, 32'h200, 32'h0, 32'h8C48_0003, 32'h0001_0001);
        glob_en = 1'b1;
        wait_off(0, "R11 done");
        glob_en = 1'b0;
        chk_eq("R6 data0", mem[32'h200 >> 2], 32'hA1A2A3A4);
        chk_eq("R6 data2", mem[32'h208 >> 2], 32'hC1C2C3C4);
        chk_eq("R6 count", 32'(log_n), 32'd6);
        chk_eq("R6 order", {log_addr[0][15:0], log_addr[1][15:0]}, 32'h0100_0200);
        chk_eq("R6 we", {31'b0, log_we[1] & ~log_we[0]}, 32'h1);
        chk_eq("R6 be", 32'(log_be[0]), 32'hF);
        chk_eq("R8 ctrl", fld(chan_ctrl, 0), 32'h8C48_0000);
        chk_eq("R9 src", fld(chan_src, 0), 32'h10C);
        chk_eq("R9 dst", fld(chan_dst, 0), 32'h20C);
        chk_eq("R11 conf", fld(chan_conf, 0), 32'h0001_0000);
        chk_eq("R12 tc", 32'(tc_raw), 32'h1);
    endtask

    task automatic t_lanes();
        clr_tc();
        poke(32'h100, 32'h44332211); poke(32'h300, 32'hFFFF_FFFF); poke(32'h204, 32'hAAAA_AAAA);
        clr_log();
        prog(0, 32'h101, 32'h300, 32'h0, 32'h0440_0002, 32'h1);
        glob_en = 1'b1;
        wait_off(0, "R7 run1");
        chk_eq("R6 be byte0", 32'(log_be[0]), 32'h2);
        chk_eq("R6 be byte1", 32'(log_be[2]), 32'h4);
        chk_eq("R7 wdata", log_wd[1], 32'h22);
        chk_eq("R7 zext", mem[32'h300 >> 2], 32'h33);
        chk_eq("R9 src byte", fld(chan_src, 0), 32'h103);
        chk_eq("R9 dst fixed", fld(chan_dst, 0), 32'h300);
        chk_eq("R12 no tc", 32'(tc_raw), 32'h0);
        clr_log();
        prog(0, 32'h102, 32'h205, 32'h0, 32'h0C04_0001, 32'h1);
        wait_off(0, "R7 run2");
        chk_eq("R6 be half", 32'(log_be[0]), 32'hC);
        chk_eq("R6 be dst", 32'(log_be[1]), 32'h2);
        chk_eq("R7 trunc", mem[32'h204 >> 2], 32'hAAAA_33AA);
        chk_eq("R9 inc", {fld(chan_src, 0)[15:0], fld(chan_dst, 0)[15:0]}, 32'h0104_0206);
        glob_en = 1'b0;
    endtask

    task automatic t_flow();
        clr_log();
        prog(1, 32'h100, 32'h380, 32'h0, 32'h0048_0001, 32'h0000_08C1);
        glob_en = 1'b1;
        repeat (30) @(negedge clk);
        chk_eq("R3 t1 idle", 32'(log_n), 32'd0);
        chk_eq("R3 t1 count", fld(chan_ctrl, 1), 32'h0048_0001);
        per_sreq[3] = 1'b1;
        wait_off(1, "R3 t1 run");
        chk_eq("R3 t1 data", mem[32'h380 >> 2], 32'h44332211);
        per_sreq = '0;
        clr_log();
        prog(1, 32'h100, 32'h380, 32'h0, 32'h0048_0001, 32'h0000_100F);
        per_breq[6] = 1'b1;
        repeat (30) @(negedge clk);
        chk_eq("R3 t2 idle", 32'(log_n), 32'd0);
        per_breq[7] = 1'b1;
        wait_off(1, "R3 t2 run");
        per_breq = '0;
        clr_log();
        prog(1, 32'h100, 32'h380, 32'h0, 32'h0048_0001, 32'h0000_1A45);
        per_sreq[2] = 1'b1;
        repeat (30) @(negedge clk);
        chk_eq("R3 t3 idle", 32'(log_n), 32'd0);
        per_breq[9] = 1'b1;
        wait_off(1, "R3 t3 run");
        chk_eq("R3 t3 count", 32'(log_n), 32'd2);
        per_sreq = '0; per_breq = '0;
    endtask

    task automatic t_gates();
        clr_log();
        per_sreq = '1; per_breq = '1;
        prog(1, 32'h100, 32'h380, 32'h0, 32'h0048_0001, 32'h0000_2801);
        repeat (30) @(negedge clk);
        chk_eq("R4 bad flow", 32'(log_n), 32'd0);
        chk_eq("R4 still on", fld(chan_conf, 1), 32'h0000_2801);
        per_sreq = '0; per_breq = '0;
        wr_reg(1, 3'd4, 32'h0004_0001);
        repeat (30) @(negedge clk);
        chk_eq("R2 halt", 32'(log_n), 32'd0);
        glob_en = 1'b0;
        wr_reg(1, 3'd4, 32'h1);
        repeat (30) @(negedge clk);
        chk_eq("R2 global off", 32'(log_n), 32'd0);
        glob_en = 1'b1;
        wait_off(1, "R2 resume");
        chk_eq("R2 ran", 32'(log_n), 32'd2);
        glob_en = 1'b0;
    endtask

    task automatic t_prio();
        clr_log();
        prog(0, 32'h100, 32'h200, 32'h0, 32'h0C48_0002, 32'h1);
        prog(1, 32'h140, 32'h240, 32'h0, 32'h0C48_0002, 32'h1);
        glob_en = 1'b1;
        wait_off(0, "R5 ch0");
        wait_off(1, "R5 ch1");
        glob_en = 1'b0;
        chk_eq("R5 count", 32'(log_n), 32'd8);
        chk_eq("R5 first", log_addr[0], 32'h100);
        chk_eq("R5 second elem", log_addr[2], 32'h104);
        chk_eq("R5 then ch1", log_addr[4], 32'h140);
    endtask

    task automatic t_lli();
        clr_tc();
        poke(32'h600, 32'h140); poke(32'h604, 32'h2C0);
        poke(32'h608, 32'h0);   poke(32'h60C, 32'h0C48_0001);
        clr_log();
        prog(1, 32'h100, 32'h280, 32'h600, 32'h8C48_0001, 32'h1);
        glob_en = 1'b1;
        wait_off(1, "R10 done");
        glob_en = 1'b0;
        chk_eq("R10 n", 32'(log_n), 32'd8);
        chk_eq("R10 p0", log_addr[2], 32'h600);
        chk_eq("R10 p4", log_addr[3], 32'h604);
        chk_eq("R10 p12", log_addr[4], 32'h60C);
        chk_eq("R10 p8", log_addr[5], 32'h608);
        chk_eq("R10 next src", log_addr[6], 32'h140);
        chk_eq("R10 next dst", log_addr[7], 32'h2C0);
        chk_eq("R10 src", fld(chan_src, 1), 32'h144);
        chk_eq("R10 ctrl", fld(chan_ctrl, 1), 32'h0C48_0000);
        chk_eq("R12 tc ch1", 32'(tc_raw), 32'h2);
        @(negedge clk); tc_clr = 2'b10;
        @(negedge clk); tc_clr = '0;
        chk_eq("R12 cleared", 32'(tc_raw), 32'h0);
    endtask

    task automatic t_zero();
        clr_log();
        prog(0, 32'h100, 32'h200, 32'h0, 32'h8000_0000, 32'h1);
        glob_en = 1'b1;
        wait_off(0, "R13 done");
        glob_en = 1'b0;
        chk_eq("R13 no access", 32'(log_n), 32'd0);
        chk_eq("R13 tc", 32'(tc_raw), 32'h1);
        chk_eq("R13 ctrl", fld(chan_ctrl, 0), 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem2mem();
        t_lanes();
        t_flow();
        t_gates();
        t_prio();
        t_lli();
        t_zero();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule